// File: doc/BRIEF.md
# Pin interrupt status controller

This block turns eight already-selected pin signals into eight interrupt requests. Each channel first passes its pin through a two-flop synchroniser. It then works in one of two modes. In edge mode, rising and falling transitions set sticky latches, and each edge type has its own enable. In level mode, the channel requests an interrupt for as long as the pin sits at a programmable active level. The choice of which physical pin feeds each channel is made outside this block.

Software reaches the block through a small register bus. The bus has a one-cycle write strobe, a two-bit register select, a data byte and a combinational read port. The status word shows one request bit per channel. Writing a 1 to a status bit has a different effect in each mode. For an edge-mode channel it clears both edge latches. For a level-mode channel it inverts the active level, which is stored in the register that holds the falling-edge enable in edge mode.

Register select values are fixed: 0 is the status word, 1 is the mode register (bit n set means channel n is in level mode), 2 is the rising-edge enable / level enable register, and 3 is the falling-edge enable / active-level register (in level mode, 1 means active high).

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, the status word, the mode register, both enable registers and `irq_o` are all 0.
- R2: A write to select 1, 2 or 3 stores the data byte, and a read of that select returns it. The registers do not change without a write.
- R3: In edge mode, a rising pin edge on a channel with its rising enable (select 2) set sets that channel's status bit. The bit appears no later than the third clock edge after the pin changes. It stays set after the pin returns low.
- R4: In edge mode, a falling pin edge on a channel with its falling enable (select 3) set sets that channel's status bit, with the same latency as R3.
- R5: An edge whose type is not enabled for the channel leaves the status bit at 0.
- R6: Writing 1 to a status bit of an edge-mode channel clears that bit. Writing 0 to any status bit changes nothing.
- R7: In level mode, a status bit is 1 exactly while the channel's level enable (select 2) is set and the synchronised pin equals the active level (select 3). Nothing is latched.
- R8: Writing 1 to a status bit of a level-mode channel inverts that channel's bit in select 3. For edge-mode channels, status writes never alter select 3.
- R9: When an enabled edge arrives in the same cycle as a write-1 clear of that channel, the edge wins and the status bit stays 1.
- R10: `irq_o` equals the status word read at select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_pin_i | input | 8 | Selected pin for each channel, asynchronous |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register, combinational |
| irq_o | output | 8 | Per-channel interrupt request |

## Verification
Two kinds of internal fault show up at the ports. A corrupted edge latch shows as a status bit that either never rises or cannot be cleared, and it appears on `irq_o` three clock edges after the pin moves. A wrong active-level or mode bit shows as an inverted request in level mode, and it appears right after the write, through the select-3 readback and `irq_o`. The collision between an edge and a clear is driven to the exact cycle, because a reversed priority there loses one interrupt and shows no other sign.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_MODE = 2'd1,
    REG_RENA = 2'd2,
    REG_FENA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic lvl_mode_i,
  input  logic ena_i,
  input  logic enf_i,
  input  logic clr_i,
  output logic stat_o
);
  logic prev_q, rise_q, fall_q;
  logic rise_ev, fall_ev;

  assign rise_ev = !lvl_mode_i && ena_i && pin_s_i && !prev_q;
  assign fall_ev = !lvl_mode_i && enf_i && !pin_s_i && prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      // a fresh edge beats a same-cycle clear
      rise_q <= rise_ev | (rise_q & ~clr_i);
      fall_q <= fall_ev | (fall_q & ~clr_i);
    end
  end

  // in level mode enf_i carries the active level
  assign stat_o = lvl_mode_i ? (ena_i && (pin_s_i == enf_i))
                             : ((rise_q && ena_i) || (fall_q && enf_i));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ch_pin_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] pin_s;
  logic [NUM_CH-1:0] mode_q, ena_q, enf_q;
  logic [NUM_CH-1:0] stat, clr;
  logic              stat_wr;

  pin_irq_sync #(.W(NUM_CH), .STAGES(SYNC_STGS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ch_pin_i),
    .q_o   (pin_s)
  );

  assign stat_wr = wr_en_i && (reg_sel_e'(addr_i) == REG_STAT);
  assign clr     = stat_wr ? (wdata_i & ~mode_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ena_q  <= '0;
      enf_q  <= '0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(addr_i))
        REG_STAT: enf_q  <= enf_q ^ (wdata_i & mode_q);
        REG_MODE: mode_q <= wdata_i;
        REG_RENA: ena_q  <= wdata_i;
        REG_FENA: enf_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pin_irq_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_s_i   (pin_s[c]),
      .lvl_mode_i(mode_q[c]),
      .ena_i     (ena_q[c]),
      .enf_i     (enf_q[c]),
      .clr_i     (clr[c]),
      .stat_o    (stat[c])
    );
  end

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_STAT: rdata_o = stat;
      REG_MODE: rdata_o = mode_q;
      REG_RENA: rdata_o = ena_q;
      REG_FENA: rdata_o = enf_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = stat;
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [NUM_CH-1:0] wdata_i,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] mode_q,
  input logic [NUM_CH-1:0] ena_q,
  input logic [NUM_CH-1:0] enf_q
);
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mode_q) && $stable(ena_q) && $stable(enf_q))); // R2

  AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (($past(irq_o & ~mode_q) & ~irq_o) == '0)); // R3

  AST_W0_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0 && wdata_i == '0)
      |=> (($past(irq_o & ~mode_q) & ~irq_o) == '0)); // R6

  AST_LVL_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & mode_q & ~ena_q) == '0); // R7

  AST_LVL_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> (enf_q == $past(enf_q ^ (wdata_i & mode_q)))); // R8
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .mode_q (mode_q),
  .ena_q  (ena_q),
  .enf_q  (enf_q)
);

// File: tb/pin_irq_ctrl_bench.sv
module pin_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, irq;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_ctrl u_pin_irq_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .ch_pin_i(pins),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; addr = 2'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
    addr = 2'd0;
  endtask

  task automatic set_pins(logic [7:0] p);
    @(negedge clk);
    pins = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset regs", d, 8'h00);
    end
    chk("R1 reset irq", irq, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    wr(2'd1, 8'hA5); rd(2'd1, d); chk("R2 mode rb", d, 8'hA5);
    wr(2'd2, 8'h3C); rd(2'd2, d); chk("R2 rena rb", d, 8'h3C);
    wr(2'd3, 8'h81); rd(2'd3, d); chk("R2 fena rb", d, 8'h81);
    rd(2'd1, d); chk("R2 mode held", d, 8'hA5);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_rise_clear();
    logic [7:0] d;
    wr(2'd2, 8'h01);
    set_pins(8'h03);
    chk("R3 rise latch", irq, 8'h01);
    chk("R5 rise disabled ch1", irq & 8'h02, 8'h00);
    rd(2'd0, d); chk("R10 stat read", d, irq);
    set_pins(8'h00);
    chk("R3 sticky after fall", irq, 8'h01);
    wr(2'd0, 8'h00); chk("R6 write0 nop", irq, 8'h01);
    wr(2'd0, 8'h02); chk("R6 other bit nop", irq, 8'h01);
    wr(2'd0, 8'h01); chk("R6 write1 clear", irq, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_fall();
    wr(2'd3, 8'h04);
    set_pins(8'h04);
    chk("R5 rise not enabled", irq, 8'h00);
    set_pins(8'h00);
    chk("R4 fall latch", irq, 8'h04);
    wr(2'd0, 8'h04); chk("R6 clear fall", irq, 8'h00);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_collide();
    wr(2'd2, 8'h08); wr(2'd3, 8'h08);
    set_pins(8'h08);
    chk("R3 ch3 rise", irq, 8'h08);
    @(negedge clk); pins = 8'h00;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 8'h08;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    chk("R9 edge beats clear", irq, 8'h08);
    wr(2'd0, 8'h08); chk("R6 clear after collide", irq, 8'h00);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(2'd1, 8'h30); wr(2'd2, 8'h30); wr(2'd3, 8'h10);
    set_pins(8'h00);
    chk("R7 low-active ch5", irq, 8'h20);
    set_pins(8'h10);
    chk("R7 both active", irq, 8'h30);
    set_pins(8'h30);
    chk("R7 ch5 inactive", irq, 8'h10);
    set_pins(8'h20);
    chk("R7 not latched", irq, 8'h00);
    rd(2'd0, d); chk("R10 level read", d, irq);
  endtask

  task automatic t_toggle();
    logic [7:0] d;
    set_pins(8'h00);
    wr(2'd0, 8'h10);
    rd(2'd3, d); chk("R8 toggle lvl", d, 8'h00);
    chk("R8 ch4 now low-active", irq, 8'h30);
    wr(2'd0, 8'h00);
    rd(2'd3, d); chk("R8 write0 nop", d, 8'h00);
    wr(2'd0, 8'h21);
    rd(2'd3, d); chk("R8 edge bit no toggle", d, 8'h20);
    chk("R8 ch5 high-active now", irq, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_rise_clear();
    t_fall();
    t_collide();
    t_level();
    t_toggle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule